// File: doc/BRIEF.md
# Down-Counting System Tick Timer

This block is a core-local periodic timer built around a 24-bit down counter. Software programs a reload value and turns the timer on. The counter then counts down to zero and refills itself from the reload value, so it produces a steady time base. Each time the count expires, the block raises a sticky wrap flag. If the tick interrupt is enabled, it also emits a one-cycle interrupt request pulse.

The counter advances on one of two step sources. It can step on every core clock, or only on cycles where an external reference tick-enable is high. It holds while a sleep input is asserted.

Access is through a simple single-cycle register port with read and write strobes, a 2-bit word address and 32-bit data. The port exposes three registers: control/status, reload value and current value. Reading the control/status register returns the wrap flag and clears it in the same access. Writing the current value register clears both the counter and the wrap flag.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control bits, the reload value, the counter and the wrap flag are all zero, and `irq_o` is low.
- R2: While enabled and stepping, the counter falls by one per step. A step taken at zero refills the counter from the reload value, so one period is reload+1 steps.
- R3: The wrap flag is set only when the counter moves from 1 to 0. A read of address 0 returns the flag in bit 16 and clears it. If a new 1-to-0 move happens in the same cycle as that read, the flag stays set.
- R4: `irq_o` is high for exactly one cycle, in the cycle after each 1-to-0 move, and only when control bit 1 is 1. The pulse does not clear the wrap flag.
- R5: A write to address 0 with bit 0 set, made while the timer is off, loads the counter with the reload value at that clock edge. Counting down starts on the following steps.
- R6: With control bit 2 at 0, the counter steps only in cycles where `ref_tick_i` is high. With bit 2 at 1, it steps every clock.
- R7: While `sleep_i` is high, the counter holds its value.
- R8: A write of any data to address 2 clears the counter and the wrap flag, and causes no `irq_o` pulse.
- R9: Address 1 holds a 24-bit reload value. Bits 31:24 read as zero and ignore writes.
- R10: With a reload value of zero, the counter stays at zero and the wrap flag is never set.
- R11: While control bit 0 is 0, the counter holds its value.
- R12: Address 0 reads with bit 0 = enable, bit 1 = tick interrupt enable, bit 2 = clock source select and bit 16 = wrap flag. All other bits read zero. A write to bit 16 has no effect.
- R13: `rdata_o` shows the addressed register in the same cycle that `rd_en_i` is high, and is zero otherwise. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word address: 0 control/status, 1 reload, 2 current value |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of `rd_en_i` |
| ref_tick_i | input | 1 | External reference tick-enable |
| sleep_i | input | 1 | Halts counting while high |
| irq_o | output | 1 | One-cycle tick interrupt request |

## Verification
The bench targets the following corner cases:

- **Flag set and read clear in the same cycle.** A design that lets the clear win would silently lose a wrap event.
- **Zero reload.** A design that treats zero as a full-range reload would keep setting the flag.
- **Turning the timer on.** A design that skips the initial load would start counting from a stale value, and the first period would be wrong.
- **Step qualification.** The bench checks that the reference tick-enable, sleep and disable each freeze the count. It also checks that a current-value write neither leaves the flag set nor fires the interrupt; a design that got that priority wrong would emit a spurious tick.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned REG_ADDR_W   = 2;
  localparam int unsigned CSR_EN_BIT   = 0;
  localparam int unsigned CSR_IE_BIT   = 1;
  localparam int unsigned CSR_SRC_BIT  = 2;
  localparam int unsigned CSR_FLAG_BIT = 16;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_CSR    = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_VALUE  = 2'd2,
    ADDR_NONE   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tick_step_gen.sv
module tick_step_gen (
  input  logic run_i,
  input  logic sleep_i,
  input  logic src_core_i,
  input  logic ref_tick_i,
  output logic step_o
);

  logic src_ok;

  assign src_ok = src_core_i | ref_tick_i;
  assign step_o = run_i & ~sleep_i & src_ok;

endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  flag_i,
  output logic [DATA_W-1:0]     rdata_o,
  output ctrl_t                 ctrl_o,
  output logic [CNT_W-1:0]      reload_o,
  output logic                  start_o,
  output logic                  cval_clr_o,
  output logic                  csr_rd_o
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             wr_csr, wr_reload;
  logic [DATA_W-1:0] csr_word, reload_word, value_word;

  assign wr_csr     = wr_en_i && (addr_i == ADDR_CSR);
  assign wr_reload  = wr_en_i && (addr_i == ADDR_RELOAD);
  assign cval_clr_o = wr_en_i && (addr_i == ADDR_VALUE);
  assign csr_rd_o   = rd_en_i && (addr_i == ADDR_CSR);
  // load only on an off-to-on transition
  assign start_o    = wr_csr && wdata_i[CSR_EN_BIT] && !ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_csr) begin
        ctrl_q.run      <= wdata_i[CSR_EN_BIT];
        ctrl_q.irq_en   <= wdata_i[CSR_IE_BIT];
        ctrl_q.src_core <= wdata_i[CSR_SRC_BIT];
      end
      if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    csr_word               = '0;
    csr_word[CSR_EN_BIT]   = ctrl_q.run;
    csr_word[CSR_IE_BIT]   = ctrl_q.irq_en;
    csr_word[CSR_SRC_BIT]  = ctrl_q.src_core;
    csr_word[CSR_FLAG_BIT] = flag_i;
    reload_word            = '0;
    reload_word[CNT_W-1:0] = reload_q;
    value_word             = '0;
    value_word[CNT_W-1:0]  = cnt_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (reg_addr_e'(addr_i))
        ADDR_CSR:    rdata_o = csr_word;
        ADDR_RELOAD: rdata_o = reload_word;
        ADDR_VALUE:  rdata_o = value_word;
        default:     rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

endmodule

// File: rtl/tick_down_cnt.sv
module tick_down_cnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic             csr_rd_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, irq_q, wrap;

  assign wrap = step_i && !clr_i && !start_i && (cnt_q == CNT_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= reload_i;
    end else if (step_i) begin
      cnt_q <= (cnt_q == CNT_ZERO) ? reload_i : cnt_q - CNT_ONE;
    end
  end

  // set has priority over read-clear so no wrap is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (clr_i)    flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (csr_rd_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap && irq_en_i;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic                  ref_tick_i,
  input  logic                  sleep_i,
  output logic                  irq_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt;
  logic             flag, step, start, cval_clr, csr_rd;

  tick_regs #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .flag_i    (flag),
    .rdata_o   (rdata_o),
    .ctrl_o    (ctrl),
    .reload_o  (reload),
    .start_o   (start),
    .cval_clr_o(cval_clr),
    .csr_rd_o  (csr_rd)
  );

  tick_step_gen step_i (
    .run_i     (ctrl.run),
    .sleep_i   (sleep_i),
    .src_core_i(ctrl.src_core),
    .ref_tick_i(ref_tick_i),
    .step_o    (step)
  );

  tick_down_cnt #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .start_i (start),
    .clr_i   (cval_clr),
    .csr_rd_i(csr_rd),
    .irq_en_i(ctrl.irq_en),
    .reload_i(reload),
    .cnt_o   (cnt),
    .flag_o  (flag),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  irq_o,
  input logic                  flag_i,
  input logic [CNT_W-1:0]      cnt_i,
  input logic [CNT_W-1:0]      reload_i,
  input logic                  run_i,
  input logic                  irq_en_i,
  input logic                  step_i,
  input logic                  start_i,
  input logic                  clr_i,
  input logic                  sleep_i,
  input logic                  rd_en_i,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0]     rdata_o
);

  // R4
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R4
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (flag_i && $past(irq_en_i)));

  // R3
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> ($past(cnt_i) == CNT_W'(1) && cnt_i == '0));

  // R2
  refill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_i && cnt_i == '0 && !clr_i && !start_i) |=> (cnt_i == $past(reload_i)));

  // R5
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !clr_i) |=> (cnt_i == $past(reload_i)));

  // R7
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !clr_i && !start_i) |=> $stable(cnt_i));

  // R8
  value_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_i == '0 && !flag_i && !irq_o));

  // R9
  reload_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_RELOAD) |-> (rdata_o[DATA_W-1:CNT_W] == '0));

  // R13
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));

endmodule

bind tick_timer tick_timer_chk #(
  .CNT_W (CNT_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .flag_i  (flag),
  .cnt_i   (cnt),
  .reload_i(reload),
  .run_i   (ctrl.run),
  .irq_en_i(ctrl.irq_en),
  .step_i  (step),
  .start_i (start),
  .clr_i   (cval_clr),
  .sleep_i (sleep_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ref_tick_i = 1'b0, sleep_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tick_timer dut_i (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .rdata_o, .ref_tick_i, .sleep_i, .irq_o
  );

  // reference model
  logic        m_en, m_ie, m_src, m_flag, m_irq;
  logic [23:0] m_reload, m_cnt;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
      m_reload = 0; m_cnt = 0;
    end else begin
      logic stp, ev;
      ev  = 1'b0;
      stp = m_en && !sleep_i && (m_src || ref_tick_i);
      if (wr_en_i && addr_i == 2) m_cnt = 0;
      else if (wr_en_i && addr_i == 0 && wdata_i[0] && !m_en) m_cnt = m_reload;
      else if (stp) begin
        if (m_cnt == 0) m_cnt = m_reload;
        else begin
          if (m_cnt == 1) ev = 1'b1;
          m_cnt = m_cnt - 1;
        end
      end
      if (wr_en_i && addr_i == 2) m_flag = 0;
      else if (ev) m_flag = 1;
      else if (rd_en_i && addr_i == 0) m_flag = 0;
      m_irq = ev && m_ie;
      if (wr_en_i && addr_i == 0) begin
        m_en = wdata_i[0]; m_ie = wdata_i[1]; m_src = wdata_i[2];
      end
      if (wr_en_i && addr_i == 1) m_reload = wdata_i[23:0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {15'b0, m_flag, 13'b0, m_src, m_ie, m_en};
      2'd1:    return {8'b0, m_reload};
      2'd2:    return {8'b0, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample 1 ns later
  task automatic bus(input bit w, input bit r, input logic [1:0] a, input logic [31:0] d,
                     input bit rt, input bit slp, input string tag, output logic [31:0] rd);
    @(negedge clk_i);
    wr_en_i = w; rd_en_i = r; addr_i = a; wdata_i = d; ref_tick_i = rt; sleep_i = slp;
    #1;
    rd = rdata_o;
    chk("R4 irq", {31'b0, irq_o}, {31'b0, m_irq});
    if (r) chk(tag, rdata_o, exp_read(a));
    else   chk("R13 idle read", rdata_o, 32'h0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] x;
    bus(1, 0, a, d, 0, 0, "", x);
  endtask

  task automatic rd(input logic [1:0] a, input string tag, output logic [31:0] v);
    bus(0, 1, a, 0, 0, 0, tag, v);
  endtask

  task automatic idle(input int n, input bit rt, input bit slp);
    logic [31:0] x;
    for (int i = 0; i < n; i++) bus(0, 0, 0, 0, rt, slp, "", x);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int seed, gap;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state, R12 layout
    rd(0, "R1 csr", v);    chk("R1 csr literal", v, 32'h0);
    rd(1, "R1 reload", v); chk("R1 reload literal", v, 32'h0);
    rd(2, "R1 value", v);  chk("R1 value literal", v, 32'h0);
    rd(3, "R13 addr3", v); chk("R13 addr3 literal", v, 32'h0);

    // R9 upper reload bits
    wr(1, 32'hFFFF_FFFF);
    rd(1, "R9 reload", v); chk("R9 upper zero", v, 32'h00FF_FFFF);

    // R12 flag bit not writable, other bits zero
    wr(0, 32'hFFFF_FFF8);
    rd(0, "R12 csr", v); chk("R12 csr literal", v, 32'h0);
    wr(0, 32'h0000_0006);
    rd(0, "R12 csr", v); chk("R12 csr bits", v, 32'h6);

    // R5 start loads reload, R2 decrement
    wr(1, 32'd5);
    wr(0, 32'h7);
    rd(2, "R5 value", v); chk("R5 loaded", v, 32'd5);
    rd(2, "R2 value", v); chk("R2 decremented", v, 32'd4);

    // R2/R4 period with reload 3
    wr(1, 32'd3);
    gap = 0;
    while (!irq_o && gap < 40) begin idle(1, 0, 0); gap++; end
    gap = 0;
    do begin idle(1, 0, 0); gap++; end while (!irq_o && gap < 40);
    chk("R2 period", gap, 32'd4);
    rd(0, "R3 csr", v);  chk("R3 flag set after irq", v, 32'h0001_0007);
    rd(0, "R3 csr", v);  chk("R3 flag cleared by read", v, 32'h7);

    // R8 value write clears
    wr(2, 32'h1234);
    rd(2, "R8 value", v); chk("R8 value zero", v, 32'h0);
    rd(0, "R8 csr", v);   chk("R8 flag clear", v, 32'h7);

    // R7 sleep holds
    idle(1, 0, 1);
    bus(0, 1, 2, 0, 0, 1, "R7 value", v);
    idle(5, 0, 1);
    bus(0, 1, 2, 0, 0, 1, "R7 value", v2);
    chk("R7 held", v2, v);

    // R6 reference tick select
    wr(0, 32'h3);
    idle(1, 0, 0);
    rd(2, "R6 value", v);
    idle(6, 0, 0);
    rd(2, "R6 value", v2);
    chk("R6 no ref no step", v2, v);
    idle(1, 1, 0);
    rd(2, "R6 value", v2);

    // R11 disable holds
    wr(0, 32'h0);
    rd(2, "R11 value", v);
    idle(5, 0, 0);
    rd(2, "R11 value", v2);
    chk("R11 held", v2, v);

    // R10 zero reload
    wr(1, 32'h0);
    wr(2, 32'h0);
    wr(0, 32'h5);
    idle(20, 0, 0);
    rd(0, "R10 csr", v); chk("R10 no flag", v, 32'h5);
    rd(2, "R10 value", v); chk("R10 at zero", v, 32'h0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [31:0] d;
      bit rt, slp;
      op  = $urandom_range(0, 99);
      rt  = $urandom_range(0, 1);
      slp = ($urandom_range(0, 9) == 0);
      if (op < 5) begin
        d = $urandom; d[0] = ($urandom_range(0, 9) != 0);
        bus(1, 0, 0, d, rt, slp, "", v);
      end else if (op < 10) begin
        d = ($urandom_range(0, 4) == 0) ? $urandom : $urandom_range(0, 9);
        bus(1, 0, 1, d, rt, slp, "", v);
      end else if (op < 12) begin
        bus(1, 0, 2, $urandom, rt, slp, "", v);
      end else if (op < 30) begin
        bus(0, 1, 0, 0, rt, slp, "R3 random csr", v);
      end else if (op < 34) begin
        bus(0, 1, 1, 0, rt, slp, "R9 random reload", v);
      end else if (op < 50) begin
        bus(0, 1, 2, 0, rt, slp, "R2 random value", v);
      end else if (op < 52) begin
        bus(0, 1, 3, 0, rt, slp, "R13 random addr3", v);
      end else begin
        bus(0, 0, 0, 0, rt, slp, "", v);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule